// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block keeps the opening instructions of recently taken branch targets, so that a taken branch does not have to wait for an instruction-cache access. The front end presents the fetch address of a branch on the lookup port. When that address hits, the block returns the first two instruction words of the target stream on the next clock, ready to be written into the instruction queue. When the front end later learns the real target words of a branch, it installs them through the allocate port. Each word carries its own valid flag, so a target that has only one usable word can still be cached.

The store has 64 entries, arranged as 16 sets of 4 ways. A pseudo-LRU tree in each set picks the way to replace. An enable input turns the whole cache off. A flush input empties it in a single cycle.

Top module: `btic`

## Requirements
- R1: After reset, `hit` and `instrValid` are 0, both instruction outputs are zero, and every entry is empty, so the first lookups miss.
- R2: The set index is `lookupAddr[5:2]` (or `allocAddr[5:2]`) and the tag is address bits [31:6]. Addresses that differ only in bits [1:0] select the same entry. The same tag under a different index is a different entry.
- R3: A lookup that hits drives `hit`=1 in the cycle after the lookup. In that cycle `instr0` and `instr1` carry the stored words, and `instrValid` carries their stored valid flags, with bit 0 for `instr0` and bit 1 for `instr1`.
- R4: A lookup that misses, or a cycle with no lookup, yields `hit`=0, `instrValid`=0 and zero instruction words in the following cycle.
- R5: While `enable` is 0, every lookup misses and every allocate is ignored. Contents written earlier survive and hit again once `enable` returns to 1.
- R6: `invalidateAll` empties every entry at the next clock edge. A lookup in the same cycle misses, and an allocate in the same cycle is dropped.
- R7: An allocate whose tag already sits in the indexed set overwrites that way with the new words, so no duplicate entry is created.
- R8: An allocate of a new tag replaces the way named by the set's 3-bit tree. Bit 0 chooses between ways {0,1} (value 0) and {2,3} (value 1). Bit 1 chooses way 0 (0) or way 1 (1). Bit 2 chooses way 2 (0) or way 3 (1). All tree bits are 0 after reset. An access to a way sets the bits on its path to point away from it. From reset, four new tags therefore fill ways 0, 2, 1, 3 in that order, and a fifth tag replaces way 0.
- R9: A lookup hit updates the tree exactly as an allocate to that way would. For example, hitting the way-0 entry of a full set whose tree is all zeros makes the next new tag replace way 2.
- R10: When an allocate and a lookup fall in the same cycle on the same set, the lookup sees the contents from before the allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Cache on (1) or off (0) |
| invalidateAll | input | 1 | Empty every entry this cycle |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | 32 | Branch fetch address to look up |
| allocValid | input | 1 | Allocate request |
| allocAddr | input | 32 | Branch address to install |
| allocInstr0 | input | 32 | First target instruction word |
| allocInstr1 | input | 32 | Second target instruction word |
| allocWordValid | input | 2 | Valid flags of the two words (bit 0 for word 0) |
| hit | output | 1 | Previous-cycle lookup hit |
| instr0 | output | 32 | First target instruction on a hit |
| instr1 | output | 32 | Second target instruction on a hit |
| instrValid | output | 2 | Valid flags of the returned words |

## Verification
Lookup and allocate can fall in the same cycle, and a flush can land on top of either. The bench drives an allocate and a lookup of the same address in one cycle. It expects a miss in the next cycle and a hit on a repeat lookup. It also raises `invalidateAll` together with a lookup of a resident address and an allocate to an empty set. Every later lookup of those addresses must then miss. Replacement order is judged by which of five tags sharing one set still hits after the fifth allocate.

// File: rtl/btic_pkg.sv
package btic_pkg;
  localparam int WAYS   = 4;
  localparam int PLRU_W = WAYS - 1;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic            flush;
    logic            lookupEn;
    logic            write;
    logic [WAYS-1:0] wayMask;
  } btic_strobe_t;
endpackage

// File: rtl/btic_ctrl.sv
module btic_ctrl
  import btic_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             invalidateAll,
  input  logic             lookupValid,
  input  logic             allocValid,
  input  logic [IDX_W-1:0] lookupSet,
  input  logic [IDX_W-1:0] allocSet,
  input  logic [WAYS-1:0]  lookupHitVec,
  input  logic [WAYS-1:0]  allocHitVec,
  output btic_strobe_t     strobe
);
  logic [PLRU_W-1:0] plruQ [SETS];
  logic [PLRU_W-1:0] allocTree;
  logic              lookupTouch;

  function automatic logic [WAYS-1:0] victimOf(input logic [PLRU_W-1:0] t);
    if (t[0]) return t[2] ? 4'b1000 : 4'b0100;
    else      return t[1] ? 4'b0010 : 4'b0001;
  endfunction

  function automatic logic [PLRU_W-1:0] touch(input logic [PLRU_W-1:0] t,
                                              input logic [WAYS-1:0] m);
    logic [PLRU_W-1:0] n;
    n = t;
    if (m[0]) begin n[0] = 1'b1; n[1] = 1'b1; end
    if (m[1]) begin n[0] = 1'b1; n[1] = 1'b0; end
    if (m[2]) begin n[0] = 1'b0; n[2] = 1'b1; end
    if (m[3]) begin n[0] = 1'b0; n[2] = 1'b0; end
    return n;
  endfunction

  always_comb begin
    strobe.flush    = invalidateAll;
    strobe.lookupEn = lookupValid && enable && !invalidateAll;
    strobe.write    = allocValid && enable && !invalidateAll;
    strobe.wayMask  = (|allocHitVec) ? allocHitVec : victimOf(plruQ[allocSet]);
  end

  assign lookupTouch = strobe.lookupEn && (|lookupHitVec);
  // An allocate to the set a lookup hit in the same cycle lands on top of the lookup update.
  assign allocTree = (lookupTouch && lookupSet == allocSet)
                   ? touch(plruQ[allocSet], lookupHitVec) : plruQ[allocSet];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) plruQ[s] <= '0;
    end else begin
      if (lookupTouch) plruQ[lookupSet] <= touch(plruQ[lookupSet], lookupHitVec);
      if (strobe.write) plruQ[allocSet] <= touch(allocTree, strobe.wayMask);
    end
  end

  a_r8_one_way: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |-> $onehot(strobe.wayMask));
endmodule

// File: rtl/btic_data.sv
module btic_data
  import btic_pkg::*;
#(
  parameter int SETS    = 16,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OFF_W   = 2,
  parameter int IDX_W   = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  btic_strobe_t       strobe,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [INSTR_W-1:0] allocInstr0,
  input  logic [INSTR_W-1:0] allocInstr1,
  input  logic [1:0]         allocWordValid,
  output logic [IDX_W-1:0]   lookupSet,
  output logic [IDX_W-1:0]   allocSet,
  output logic [WAYS-1:0]    lookupHitVec,
  output logic [WAYS-1:0]    allocHitVec,
  output logic               hitQ,
  output logic [INSTR_W-1:0] instr0Q,
  output logic [INSTR_W-1:0] instr1Q,
  output logic [1:0]         instrValidQ
);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int ENTRIES = SETS * WAYS;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [INSTR_W-1:0] word0Q [ENTRIES];
  logic [INSTR_W-1:0] word1Q [ENTRIES];
  logic [1:0]         wvQ    [ENTRIES];

  logic [TAG_W-1:0]   lookupTag, allocTag;
  logic [INSTR_W-1:0] sel0, sel1;
  logic [1:0]         selV;

  assign lookupSet = lookupAddr[OFF_W +: IDX_W];
  assign allocSet  = allocAddr[OFF_W +: IDX_W];
  assign lookupTag = lookupAddr[ADDR_W-1 -: TAG_W];
  assign allocTag  = allocAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lookupHitVec[w] = validQ[int'(lookupSet)*WAYS + w]
                          && tagQ[int'(lookupSet)*WAYS + w] == lookupTag;
    assign allocHitVec[w]  = validQ[int'(allocSet)*WAYS + w]
                          && tagQ[int'(allocSet)*WAYS + w] == allocTag;
  end

  always_comb begin
    sel0 = '0;
    sel1 = '0;
    selV = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lookupHitVec[w]) begin
        sel0 = sel0 | word0Q[int'(lookupSet)*WAYS + w];
        sel1 = sel1 | word1Q[int'(lookupSet)*WAYS + w];
        selV = selV | wvQ[int'(lookupSet)*WAYS + w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) validQ <= '0;
    else if (strobe.write)
      for (int w = 0; w < WAYS; w++)
        if (strobe.wayMask[w]) validQ[int'(allocSet)*WAYS + w] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.write)
      for (int w = 0; w < WAYS; w++)
        if (strobe.wayMask[w]) begin
          tagQ[int'(allocSet)*WAYS + w]   <= allocTag;
          word0Q[int'(allocSet)*WAYS + w] <= allocInstr0;
          word1Q[int'(allocSet)*WAYS + w] <= allocInstr1;
          wvQ[int'(allocSet)*WAYS + w]    <= allocWordValid;
        end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ        <= 1'b0;
      instr0Q     <= '0;
      instr1Q     <= '0;
      instrValidQ <= '0;
    end else begin
      hitQ        <= strobe.lookupEn && (|lookupHitVec);
      instr0Q     <= strobe.lookupEn ? sel0 : '0;
      instr1Q     <= strobe.lookupEn ? sel1 : '0;
      instrValidQ <= strobe.lookupEn ? selV : '0;
    end
  end

  a_r7_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookupEn |-> $onehot0(lookupHitVec));
  a_r4_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (instrValidQ == 2'b00 && instr0Q == '0 && instr1Q == '0));
endmodule

// File: rtl/btic.sv
module btic
  import btic_pkg::*;
#(
  parameter int SETS    = 16,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               invalidateAll,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               allocValid,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [INSTR_W-1:0] allocInstr0,
  input  logic [INSTR_W-1:0] allocInstr1,
  input  logic [1:0]         allocWordValid,
  output logic               hit,
  output logic [INSTR_W-1:0] instr0,
  output logic [INSTR_W-1:0] instr1,
  output logic [1:0]         instrValid
);
  localparam int IDX_W = $clog2(SETS);

  btic_strobe_t     strobe;
  logic [IDX_W-1:0] lookupSet, allocSet;
  logic [WAYS-1:0]  lookupHitVec, allocHitVec;

  btic_ctrl #(.SETS(SETS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .invalidateAll(invalidateAll),
    .lookupValid(lookupValid), .allocValid(allocValid),
    .lookupSet(lookupSet), .allocSet(allocSet),
    .lookupHitVec(lookupHitVec), .allocHitVec(allocHitVec), .strobe(strobe)
  );

  btic_data #(.SETS(SETS), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupAddr(lookupAddr), .allocAddr(allocAddr),
    .allocInstr0(allocInstr0), .allocInstr1(allocInstr1), .allocWordValid(allocWordValid),
    .lookupSet(lookupSet), .allocSet(allocSet),
    .lookupHitVec(lookupHitVec), .allocHitVec(allocHitVec),
    .hitQ(hit), .instr0Q(instr0), .instr1Q(instr1), .instrValidQ(instrValid)
  );

  a_r5_disabled_miss: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !hit);
  a_r6_flush_miss: assert property (@(posedge clk) disable iff (!rstN)
    invalidateAll |=> !hit);
endmodule

// File: tb/sim_btic.sv
module sim_btic;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        isAlloc;
    logic [31:0] addr;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [1:0]  wv;
    logic        expHit;
  } vec_t;

  // Set 0 tags 1..6: A=0x040 B=0x080 C=0x0C0 D=0x100 E=0x140 G=0x180; F=0x044 is set 1.
  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h040, 32'h0,  32'h0,  2'b00, 1'b0}, // R4 cold miss
    '{1'b1, 32'h040, 32'h11, 32'h12, 2'b11, 1'b0}, // alloc A -> way0
    '{1'b0, 32'h040, 32'h11, 32'h12, 2'b11, 1'b1}, // R3 hit A
    '{1'b0, 32'h042, 32'h11, 32'h12, 2'b11, 1'b1}, // R2 low bits ignored
    '{1'b0, 32'h044, 32'h0,  32'h0,  2'b00, 1'b0}, // R2 other set misses
    '{1'b1, 32'h080, 32'h21, 32'h22, 2'b01, 1'b0}, // alloc B -> way2
    '{1'b1, 32'h0C0, 32'h31, 32'h32, 2'b11, 1'b0}, // alloc C -> way1
    '{1'b1, 32'h100, 32'h41, 32'h42, 2'b10, 1'b0}, // alloc D -> way3
    '{1'b0, 32'h040, 32'h11, 32'h12, 2'b11, 1'b1}, // R9 hit A moves victim to way2
    '{1'b1, 32'h140, 32'h51, 32'h52, 2'b11, 1'b0}, // alloc E evicts B
    '{1'b0, 32'h080, 32'h0,  32'h0,  2'b00, 1'b0}, // R9 B gone
    '{1'b0, 32'h140, 32'h51, 32'h52, 2'b11, 1'b1}, // R8 E present
    '{1'b0, 32'h100, 32'h41, 32'h42, 2'b10, 1'b1}, // R3 partial valid word1
    '{1'b0, 32'h0C0, 32'h31, 32'h32, 2'b11, 1'b1}, // R8 C present
    '{1'b1, 32'h040, 32'h61, 32'h62, 2'b01, 1'b0}, // R7 re-alloc A overwrites way0
    '{1'b0, 32'h040, 32'h61, 32'h62, 2'b01, 1'b1}, // R7 new words
    '{1'b1, 32'h180, 32'h71, 32'h72, 2'b11, 1'b0}, // R8 alloc G evicts E (way2)
    '{1'b0, 32'h140, 32'h0,  32'h0,  2'b00, 1'b0}, // R8 E gone
    '{1'b0, 32'h040, 32'h61, 32'h62, 2'b01, 1'b1}  // R7 A still single and present
  };

  logic        clk = 1'b0;
  logic        rstN, enable, invalidateAll, lookupValid, allocValid;
  logic [31:0] lookupAddr, allocAddr, allocInstr0, allocInstr1;
  logic [1:0]  allocWordValid;
  logic        hit;
  logic [31:0] instr0, instr1;
  logic [1:0]  instrValid;
  int          nRun = 0, nFail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btic u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .invalidateAll(invalidateAll),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .allocValid(allocValid), .allocAddr(allocAddr),
    .allocInstr0(allocInstr0), .allocInstr1(allocInstr1), .allocWordValid(allocWordValid),
    .hit(hit), .instr0(instr0), .instr1(instr1), .instrValid(instrValid)
  );

  task automatic check(input string req, input logic eHit, input logic [31:0] e0,
                       input logic [31:0] e1, input logic [1:0] eV);
    logic [31:0] x0, x1;
    logic [1:0]  xv;
    x0 = eHit ? e0 : 32'h0;
    x1 = eHit ? e1 : 32'h0;
    xv = eHit ? eV : 2'b00;
    nRun++;
    if (hit !== eHit || instr0 !== x0 || instr1 !== x1 || instrValid !== xv) begin
      nFail++;
      $display("FAIL %s: got hit=%b i0=%h i1=%h v=%b, expected hit=%b i0=%h i1=%h v=%b",
               req, hit, instr0, instr1, instrValid, eHit, x0, x1, xv);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic en, input logic inv, input logic lv, input logic [31:0] la,
                      input logic av, input logic [31:0] aa, input logic [31:0] w0,
                      input logic [31:0] w1, input logic [1:0] wv);
    enable = en; invalidateAll = inv;
    lookupValid = lv; lookupAddr = la;
    allocValid = av; allocAddr = aa;
    allocInstr0 = w0; allocInstr1 = w1; allocWordValid = wv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic en, input logic [31:0] a);
    step(en, 1'b0, 1'b1, a, 1'b0, 32'h0, 32'h0, 32'h0, 2'b00);
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                     input logic [1:0] wv);
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b1, a, w0, w1, wv);
  endtask

  initial begin
    rstN = 1'b0;
    enable = 1'b1; invalidateAll = 1'b0; lookupValid = 1'b0; allocValid = 1'b0;
    lookupAddr = '0; allocAddr = '0; allocInstr0 = '0; allocInstr1 = '0; allocWordValid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", 1'b0, 32'h0, 32'h0, 2'b00);
    rstN = 1'b1;
    look(1'b1, 32'h0C0);
    check("R1 empty after reset", 1'b0, 32'h0, 32'h0, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isAlloc) put(VECS[i].addr, VECS[i].w0, VECS[i].w1, VECS[i].wv);
      else begin
        look(1'b1, VECS[i].addr);
        check($sformatf("R2/R3/R4/R7/R8/R9 vector %0d", i), VECS[i].expHit,
              VECS[i].w0, VECS[i].w1, VECS[i].wv);
      end
    end

    // R5: disabled lookup misses, disabled allocate dropped, contents survive.
    look(1'b0, 32'h040);
    check("R5 disabled lookup", 1'b0, 32'h0, 32'h0, 2'b00);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h048, 32'h81, 32'h82, 2'b11);
    look(1'b1, 32'h048);
    check("R5 disabled allocate ignored", 1'b0, 32'h0, 32'h0, 2'b00);
    look(1'b1, 32'h040);
    check("R5 contents survive", 1'b1, 32'h61, 32'h62, 2'b01);

    // R10: lookup and allocate of the same address in one cycle.
    step(1'b1, 1'b0, 1'b1, 32'h048, 1'b1, 32'h048, 32'h81, 32'h82, 2'b11);
    check("R10 same-cycle lookup sees old state", 1'b0, 32'h0, 32'h0, 2'b00);
    look(1'b1, 32'h048);
    check("R10 allocate took effect", 1'b1, 32'h81, 32'h82, 2'b11);

    // R6: flush with a same-cycle lookup hit candidate and a same-cycle allocate.
    step(1'b1, 1'b1, 1'b1, 32'h040, 1'b1, 32'h04C, 32'h91, 32'h92, 2'b11);
    check("R6 same-cycle lookup misses", 1'b0, 32'h0, 32'h0, 2'b00);
    look(1'b1, 32'h040);
    check("R6 A flushed", 1'b0, 32'h0, 32'h0, 2'b00);
    look(1'b1, 32'h048);
    check("R6 H flushed", 1'b0, 32'h0, 32'h0, 2'b00);
    look(1'b1, 32'h04C);
    check("R6 same-cycle allocate dropped", 1'b0, 32'h0, 32'h0, 2'b00);
    put(32'h04C, 32'hA1, 32'hA2, 2'b01);
    look(1'b1, 32'h04C);
    check("R6 usable after flush", 1'b1, 32'hA1, 32'hA2, 2'b01);
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 2'b00);
    check("R4 idle cycle output", 1'b0, 32'h0, 32'h0, 2'b00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule